// File: doc/BRIEF.md
# Interrupt Input Request Capture

This block sits at the input side of an I/O interrupt controller. It accepts level-change reports for its input pins, one report per cycle, each carrying a pin number and the new level. It keeps one bit per pin holding the last level seen and one bit per pin holding an outstanding request. A report whose level matches the stored bit has no effect. Each pin's routing entry sets two things: whether a request follows the input level or is latched on a rising edge, and whether the pin is masked.

When a request becomes outstanding on an unmasked pin, a small service sequencer issues a one-cycle service pulse together with the pin number. The sequencer has two states. In `SVC_IDLE` it waits until some pin holds an unserviced, unmasked request. On the transition `IDLE->ISSUE` it records the lowest such pin number. In `SVC_ISSUE` it drives the pulse and retires that pin's service request. The `ISSUE->IDLE` transition always happens after one cycle. A delivery acknowledge carrying a pin number withdraws that pin's request. Software programs the routing entries through an 8-bit select register and a 32-bit data window.

Top module: `intr_capture`

## Requirements
- R1: A report (`pin_valid`=1) whose `pin_level` equals the stored bit `in_level[pin_idx]` leaves `in_level` and `req_pend` unchanged.
- R2: A report that raises a pin from 0 to 1 sets `in_level` and `req_pend` for that pin after the next clock edge, in either trigger mode.
- R3: For a level-triggered pin (entry low word bit 15 = 1), a report that drops the pin from 1 to 0 clears both its `in_level` and `req_pend` bits.
- R4: For an edge-triggered pin (bit 15 = 0), a drop from 1 to 0 clears `in_level` only, and `req_pend` stays set.
- R5: A request that becomes outstanding on an unmasked pin produces `svc_pulse` high for exactly one cycle, with `svc_idx` equal to the pin. The pulse is visible in the second cycle after the clock edge that took the report.
- R6: A masked pin (entry low word bit 16 = 1) still records its level and its request but raises no pulse. Writing the low word with bit 16 = 0 while the request is outstanding produces the pulse.
- R7: `ack_valid` with `ack_idx` clears that pin's `req_pend` bit. The exception is a level-triggered pin whose stored level is 1: its bit stays set.
- R8: A report or acknowledge with a pin number of 24 or more changes nothing.
- R9: After reset, every entry's low word reads 0x00010000 and its high word reads 0. `in_level`, `req_pend` and `svc_pulse` are all 0.
- R10: Writing `sel_wdata` with `sel_we` sets the select value. Select value 0x10+2n reaches the low word of pin n and 0x11+2n reaches its high word. `data_we` writes the selected word and `data_rdata` returns it. Any select value outside 0x10..0x3F reads 0.
- R11: The trigger mode used for a report is the one in the pin's entry when that report arrives, not the one in force when the pin last rose.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pin_valid | input | 1 | Level report strobe |
| pin_idx | input | 5 | Pin number of the report |
| pin_level | input | 1 | New level of the reported pin |
| ack_valid | input | 1 | Delivery acknowledge strobe |
| ack_idx | input | 5 | Pin number being acknowledged |
| sel_we | input | 1 | Write strobe for the select register |
| sel_wdata | input | 8 | New select value |
| data_we | input | 1 | Write strobe for the data window |
| data_wdata | input | 32 | Data written to the selected word |
| data_rdata | output | 32 | Selected word, or 0 outside the window |
| svc_pulse | output | 1 | One-cycle service request |
| svc_idx | output | 5 | Pin number being serviced |
| in_level | output | 24 | Stored level per pin |
| req_pend | output | 24 | Outstanding request per pin |

## Verification
The main function is driven with a sequence of reports and acknowledges on one edge-triggered pin and one level-triggered pin. That sequence separates the rising, falling and repeated-level cases. It also shows that an acknowledge behaves differently depending on trigger mode and on the stored level. A masked pin that is later unmasked separates a request that was recorded from one that was serviced. Changing a pin's mode between its rise and its fall shows which entry value the fall used. Reports with pin numbers 24 and 31 show that out-of-range numbers are dropped.

// File: rtl/intr_cap_pkg.sv
package intr_cap_pkg;
    localparam int NUM_PINS  = 24;
    localparam int IDX_W     = 5;
    localparam int WORD_W    = 32;
    localparam int SEL_W     = 8;
    localparam int WIN_BASE  = 16;
    localparam int TRIG_BIT  = 15;
    localparam int MASK_BIT  = 16;
    localparam logic [31:0] LO_RESET = 32'h0001_0000;

    typedef enum logic [0:0] {
        SVC_IDLE  = 1'b0,
        SVC_ISSUE = 1'b1
    } svc_state_t;
endpackage

// File: rtl/intr_redir_table.sv
module intr_redir_table
    import intr_cap_pkg::*;
#(
    parameter int NPINS = NUM_PINS,
    parameter int IW    = IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_we,
    input  logic [SEL_W-1:0]  sel_wdata,
    input  logic              data_we,
    input  logic [WORD_W-1:0] data_wdata,
    output logic [WORD_W-1:0] data_rdata,
    output logic [NPINS-1:0]  trig_lvl,
    output logic [NPINS-1:0]  masked,
    output logic [NPINS-1:0]  unmask_evt
);
    localparam int WIN_END = WIN_BASE + 2 * NPINS;

    logic [SEL_W-1:0]  sel_q;
    logic [SEL_W-1:0]  slot;
    logic              win_hit;
    logic              win_hi;
    logic [IW-1:0]     win_pin;
    logic [WORD_W-1:0] lo_q [NPINS];
    logic [WORD_W-1:0] hi_q [NPINS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sel_q <= '0;
        else if (sel_we) sel_q <= sel_wdata;
    end

    always_comb begin
        slot    = sel_q - SEL_W'(WIN_BASE);
        win_hit = (sel_q >= SEL_W'(WIN_BASE)) && (sel_q < SEL_W'(WIN_END));
        win_hi  = slot[0];
        win_pin = IW'(slot >> 1);
    end

    for (genvar g = 0; g < NPINS; g++) begin : g_entry
        logic hit_g;
        assign hit_g = data_we && win_hit && (win_pin == IW'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lo_q[g] <= LO_RESET;
                hi_q[g] <= '0;
            end else if (hit_g) begin
                if (win_hi) hi_q[g] <= data_wdata;
                else        lo_q[g] <= data_wdata;
            end
        end

        assign trig_lvl[g]   = lo_q[g][TRIG_BIT];
        assign masked[g]     = lo_q[g][MASK_BIT];
        assign unmask_evt[g] = hit_g && !win_hi && lo_q[g][MASK_BIT]
                               && !data_wdata[MASK_BIT];
    end

    always_comb begin
        data_rdata = '0;
        if (win_hit) data_rdata = win_hi ? hi_q[win_pin] : lo_q[win_pin];
    end
endmodule

// File: rtl/intr_req_track.sv
module intr_req_track
    import intr_cap_pkg::*;
#(
    parameter int NPINS = NUM_PINS,
    parameter int IW    = IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_valid,
    input  logic [IW-1:0]    pin_idx,
    input  logic             pin_level,
    input  logic             ack_valid,
    input  logic [IW-1:0]    ack_idx,
    input  logic [NPINS-1:0] trig_lvl,
    input  logic [NPINS-1:0] unmask_evt,
    input  logic [NPINS-1:0] svc_clr,
    output logic [NPINS-1:0] lvl_q,
    output logic [NPINS-1:0] pend_q,
    output logic [NPINS-1:0] svc_req_q
);
    logic [NPINS-1:0] lvl_n, pend_n, rise, svc_n;

    always_comb begin
        lvl_n  = lvl_q;
        pend_n = pend_q;
        rise   = '0;
        for (int i = 0; i < NPINS; i++) begin
            // acknowledge first; a same-cycle level report overrides it
            if (ack_valid && ack_idx == IW'(i) && !(trig_lvl[i] && lvl_q[i]))
                pend_n[i] = 1'b0;
            if (pin_valid && pin_idx == IW'(i) && pin_level != lvl_q[i]) begin
                lvl_n[i] = pin_level;
                if (pin_level) begin
                    pend_n[i] = 1'b1;
                    rise[i]   = 1'b1;
                end else if (trig_lvl[i]) begin
                    pend_n[i] = 1'b0;
                end
            end
        end
        svc_n = ((svc_req_q & ~svc_clr) | rise | (unmask_evt & pend_q)) & pend_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q     <= '0;
            pend_q    <= '0;
            svc_req_q <= '0;
        end else begin
            lvl_q     <= lvl_n;
            pend_q    <= pend_n;
            svc_req_q <= svc_n;
        end
    end
endmodule

// File: rtl/intr_svc_fsm.sv
module intr_svc_fsm
    import intr_cap_pkg::*;
#(
    parameter int NPINS = NUM_PINS,
    parameter int IW    = IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] svc_req,
    input  logic [NPINS-1:0] masked,
    output logic [NPINS-1:0] svc_clr,
    output logic             svc_pulse,
    output logic [IW-1:0]    svc_idx
);
    svc_state_t       state_q, state_n;
    logic [IW-1:0]    idx_q, pick;
    logic [NPINS-1:0] elig;

    always_comb begin
        elig = svc_req & ~masked;
        pick = '0;
        for (int i = NPINS - 1; i >= 0; i--)
            if (elig[i]) pick = IW'(i);
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            SVC_IDLE:  if (|elig) state_n = SVC_ISSUE;
            SVC_ISSUE: state_n = SVC_IDLE;
            default:   state_n = SVC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SVC_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_n;
            if (state_q == SVC_IDLE && state_n == SVC_ISSUE) idx_q <= pick;
        end
    end

    always_comb begin
        svc_pulse = 1'b0;
        svc_clr   = '0;
        unique case (state_q)
            SVC_IDLE:  ;
            SVC_ISSUE: begin
                svc_pulse       = 1'b1;
                svc_clr[idx_q]  = 1'b1;
            end
            default: ;
        endcase
    end

    assign svc_idx = idx_q;
endmodule

// File: rtl/intr_capture.sv
module intr_capture
    import intr_cap_pkg::*;
#(
    parameter int NPINS = NUM_PINS,
    parameter int IW    = IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_valid,
    input  logic [IW-1:0]     pin_idx,
    input  logic              pin_level,
    input  logic              ack_valid,
    input  logic [IW-1:0]     ack_idx,
    input  logic              sel_we,
    input  logic [SEL_W-1:0]  sel_wdata,
    input  logic              data_we,
    input  logic [WORD_W-1:0] data_wdata,
    output logic [WORD_W-1:0] data_rdata,
    output logic              svc_pulse,
    output logic [IW-1:0]     svc_idx,
    output logic [NPINS-1:0]  in_level,
    output logic [NPINS-1:0]  req_pend
);
    logic [NPINS-1:0] trig_lvl, masked, unmask_evt, svc_clr, svc_req;

    intr_redir_table #(.NPINS(NPINS), .IW(IW)) u_table (
        .clk(clk), .rst_n(rst_n),
        .sel_we(sel_we), .sel_wdata(sel_wdata),
        .data_we(data_we), .data_wdata(data_wdata), .data_rdata(data_rdata),
        .trig_lvl(trig_lvl), .masked(masked), .unmask_evt(unmask_evt)
    );

    intr_req_track #(.NPINS(NPINS), .IW(IW)) u_track (
        .clk(clk), .rst_n(rst_n),
        .pin_valid(pin_valid), .pin_idx(pin_idx), .pin_level(pin_level),
        .ack_valid(ack_valid), .ack_idx(ack_idx),
        .trig_lvl(trig_lvl), .unmask_evt(unmask_evt), .svc_clr(svc_clr),
        .lvl_q(in_level), .pend_q(req_pend), .svc_req_q(svc_req)
    );

    intr_svc_fsm #(.NPINS(NPINS), .IW(IW)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .svc_req(svc_req), .masked(masked), .svc_clr(svc_clr),
        .svc_pulse(svc_pulse), .svc_idx(svc_idx)
    );
endmodule

// File: rtl/intr_capture_chk.sv
module intr_capture_chk #(
    parameter int NPINS = 24,
    parameter int IW    = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pin_valid,
    input logic [IW-1:0]    pin_idx,
    input logic             pin_level,
    input logic             ack_valid,
    input logic [NPINS-1:0] lvl_q,
    input logic [NPINS-1:0] pend_q,
    input logic [NPINS-1:0] trig_lvl,
    input logic             svc_pulse
);
    logic in_rng;
    assign in_rng = pin_idx < IW'(NPINS);

    a_r1_same_level_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        pin_valid && in_rng && !ack_valid && pin_level == lvl_q[pin_idx]
        |=> $stable(lvl_q) && $stable(pend_q));

    a_r2_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
        pin_valid && in_rng && pin_level && !lvl_q[pin_idx]
        |=> lvl_q[$past(pin_idx)] && pend_q[$past(pin_idx)]);

    a_r3_level_fall_clears: assert property (@(posedge clk) disable iff (!rst_n)
        pin_valid && in_rng && !pin_level && lvl_q[pin_idx] && trig_lvl[pin_idx]
        |=> !lvl_q[$past(pin_idx)] && !pend_q[$past(pin_idx)]);

    a_r4_edge_fall_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        pin_valid && in_rng && !ack_valid && !pin_level && lvl_q[pin_idx]
        && !trig_lvl[pin_idx] && pend_q[pin_idx]
        |=> !lvl_q[$past(pin_idx)] && pend_q[$past(pin_idx)]);

    a_r5_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        svc_pulse |=> !svc_pulse);

    a_r8_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
        pin_valid && !in_rng && !ack_valid |=> $stable(lvl_q) && $stable(pend_q));
endmodule

bind intr_capture intr_capture_chk #(.NPINS(NPINS), .IW(IW)) u_chk (
    .clk(clk), .rst_n(rst_n), .pin_valid(pin_valid), .pin_idx(pin_idx),
    .pin_level(pin_level), .ack_valid(ack_valid), .lvl_q(in_level),
    .pend_q(req_pend), .trig_lvl(trig_lvl), .svc_pulse(svc_pulse)
);

// File: tb/test_intr_capture.sv
module test_intr_capture;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin_valid = 1'b0, pin_level = 1'b0, ack_valid = 1'b0;
    logic [4:0]  pin_idx = '0, ack_idx = '0;
    logic        sel_we = 1'b0, data_we = 1'b0;
    logic [7:0]  sel_wdata = '0;
    logic [31:0] data_wdata = '0, data_rdata;
    logic        svc_pulse;
    logic [4:0]  svc_idx;
    logic [23:0] in_level, req_pend;
    int checks = 0, errors = 0;

    always #2 clk = ~clk;

    intr_capture i_intr_capture (
        .clk(clk), .rst_n(rst_n), .pin_valid(pin_valid), .pin_idx(pin_idx),
        .pin_level(pin_level), .ack_valid(ack_valid), .ack_idx(ack_idx),
        .sel_we(sel_we), .sel_wdata(sel_wdata), .data_we(data_we),
        .data_wdata(data_wdata), .data_rdata(data_rdata), .svc_pulse(svc_pulse),
        .svc_idx(svc_idx), .in_level(in_level), .req_pend(req_pend)
    );

    typedef struct packed {
        logic       is_ack;
        logic [4:0] idx;
        logic       lvl;
        logic       exp_lvl;
        logic       exp_pend;
    } vec_t;

    // pin 3 edge-triggered, pin 5 level-triggered
    localparam vec_t VECS [12] = '{
        '{1'b0, 5'd3, 1'b1, 1'b1, 1'b1},  // R2 rise
        '{1'b0, 5'd3, 1'b1, 1'b1, 1'b1},  // R1 repeat high
        '{1'b0, 5'd3, 1'b0, 1'b0, 1'b1},  // R4 edge fall keeps
        '{1'b1, 5'd3, 1'b0, 1'b0, 1'b0},  // R7 ack clears
        '{1'b0, 5'd3, 1'b0, 1'b0, 1'b0},  // R1 repeat low
        '{1'b0, 5'd5, 1'b1, 1'b1, 1'b1},  // R2 rise level pin
        '{1'b1, 5'd5, 1'b0, 1'b1, 1'b1},  // R7 ack on high level pin kept
        '{1'b0, 5'd5, 1'b0, 1'b0, 1'b0},  // R3 level fall clears
        '{1'b0, 5'd5, 1'b1, 1'b1, 1'b1},  // R2
        '{1'b0, 5'd3, 1'b1, 1'b1, 1'b1},  // R2
        '{1'b1, 5'd3, 1'b0, 1'b1, 1'b0},  // R7 edge ack while high
        '{1'b0, 5'd5, 1'b0, 1'b0, 1'b0}   // R3
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report(input logic [4:0] idx, input logic lvl);
        pin_valid = 1'b1; pin_idx = idx; pin_level = lvl;
        @(negedge clk);
        pin_valid = 1'b0;
    endtask

    task automatic ack(input logic [4:0] idx);
        ack_valid = 1'b1; ack_idx = idx;
        @(negedge clk);
        ack_valid = 1'b0;
    endtask

    task automatic set_sel(input logic [7:0] v);
        sel_we = 1'b1; sel_wdata = v;
        @(negedge clk);
        sel_we = 1'b0;
    endtask

    task automatic wr(input logic [7:0] s, input logic [31:0] v);
        set_sel(s);
        data_we = 1'b1; data_wdata = v;
        @(negedge clk);
        data_we = 1'b0;
    endtask

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [23:0] lv_snap, pd_snap;
        logic        seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 reset defaults
        chk("R9 in_level", {8'h0, in_level}, 32'h0);
        chk("R9 req_pend", {8'h0, req_pend}, 32'h0);
        chk("R9 svc_pulse", {31'h0, svc_pulse}, 32'h0);
        set_sel(8'h10);
        chk("R9 pin0 low", data_rdata, 32'h0001_0000);
        set_sel(8'h3E);
        chk("R9 pin23 low", data_rdata, 32'h0001_0000);
        set_sel(8'h3F);
        chk("R9 pin23 high", data_rdata, 32'h0);

        // R10 window decode
        wr(8'h15, 32'h1234_5678);
        chk("R10 pin2 high", data_rdata, 32'h1234_5678);
        set_sel(8'h14);
        chk("R10 pin2 low", data_rdata, 32'h0001_0000);
        set_sel(8'h40);
        chk("R10 above window", data_rdata, 32'h0);
        set_sel(8'h0F);
        chk("R10 below window", data_rdata, 32'h0);

        // configure pin 3 edge unmasked, pin 5 level unmasked
        wr(8'h16, 32'h0000_0000);
        wr(8'h1A, 32'h0000_8000);
        chk("R10 pin5 low", data_rdata, 32'h0000_8000);

        for (int k = 0; k < 12; k++) begin
            if (VECS[k].is_ack) ack(VECS[k].idx);
            else report(VECS[k].idx, VECS[k].lvl);
            chk($sformatf("vec%0d R1/R2/R3/R4/R7 level", k),
                {31'h0, in_level[VECS[k].idx]}, {31'h0, VECS[k].exp_lvl});
            chk($sformatf("vec%0d R1/R2/R3/R4/R7 pend", k),
                {31'h0, req_pend[VECS[k].idx]}, {31'h0, VECS[k].exp_pend});
        end
        repeat (4) @(negedge clk);

        // R5 pulse timing on pin 7 (edge, unmasked)
        wr(8'h1E, 32'h0);
        report(5'd7, 1'b1);
        chk("R5 no pulse one cycle after", {31'h0, svc_pulse}, 32'h0);
        @(negedge clk);
        chk("R5 pulse second cycle", {31'h0, svc_pulse}, 32'h1);
        chk("R5 pulse index", {27'h0, svc_idx}, 32'd7);
        @(negedge clk);
        chk("R5 pulse single cycle", {31'h0, svc_pulse}, 32'h0);

        // R6 masked pin 9 (default masked, edge)
        report(5'd9, 1'b1);
        chk("R6 masked pend recorded", {31'h0, req_pend[9]}, 32'h1);
        seen = 1'b0;
        for (int c = 0; c < 4; c++) begin
            if (svc_pulse) seen = 1'b1;
            @(negedge clk);
        end
        chk("R6 masked no pulse", {31'h0, seen}, 32'h0);
        wr(8'h22, 32'h0);
        seen = 1'b0;
        for (int c = 0; c < 4; c++) begin
            if (svc_pulse && svc_idx == 5'd9) seen = 1'b1;
            @(negedge clk);
        end
        chk("R6 pulse after unmask", {31'h0, seen}, 32'h1);

        // R8 out-of-range pin numbers
        lv_snap = in_level; pd_snap = req_pend;
        report(5'd24, 1'b1);
        report(5'd31, 1'b1);
        ack(5'd30);
        chk("R8 level unchanged", {8'h0, in_level}, {8'h0, lv_snap});
        chk("R8 pend unchanged", {8'h0, req_pend}, {8'h0, pd_snap});

        // R11 mode taken at report time: pin 20 rises as edge, falls as level
        report(5'd20, 1'b1);
        wr(8'h38, 32'h0001_8000);
        report(5'd20, 1'b0);
        chk("R11 pend cleared by level fall", {31'h0, req_pend[20]}, 32'h0);
        chk("R11 level cleared", {31'h0, in_level[20]}, 32'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule